// File: doc/BRIEF.md
# Indirect Register and Memory Access Window

This block is a slave on a device's configuration port. It lets a host reach the device's internal register block and local memory without a memory-mapped window. The host writes a position into a cursor register and then reads or writes a data port. The block turns each data-port access into a single dword transfer on a request/acknowledge backend bus. Two independent cursor/data pairs exist: one selects a location in the register block and one selects a location in local memory. This mode does not depend on any other access path and can be used alongside one.

A control register holds an enable bit, and data-port traffic is honoured only while that bit is set. The register cursor is also checked against two disjoint windows of the register block before anything is forwarded. The gap between the two windows never reaches the backend. A refused access completes on the configuration port with no backend activity. A refused read returns zero, a refused write is dropped, and both set a sticky error flag.

Top module: `cfg_indirect_window`

## Requirements
- R1: After reset the control register, both cursors and the error flag read as zero, and no backend request is active.
- R2: Offset 0x68 is the control register. Only bit 7, the enable bit, is stored, and every other bit reads as zero.
- R3: Offset 0x78 is the register cursor (18 bits) and offset 0x7C is the memory cursor (24 bits). Upper bits beyond the width are discarded, bits [1:0] always read as zero, and backend addresses are always dword aligned.
- R4: While enabled and the register cursor is in a valid window, an access to offset 0x80 issues exactly one backend transfer with bk_space = 0, bk_addr equal to the register cursor and bk_we equal to the host's write flag. A read returns bk_rdata, and a write carries the host's data on bk_wdata.
- R5: While enabled, an access to offset 0x84 issues exactly one backend transfer with bk_space = 1 at the memory cursor, with the same data behaviour as R4.
- R6: The register cursor is valid only in 0x00000–0x07FFF and 0x30000–0x387FF. A 0x80 access with the cursor outside both windows issues no backend request, reads zero, drops the write and sets the error flag.
- R7: With the enable bit clear, an access to 0x80 or 0x84 issues no backend request, reads zero, drops the write and sets the error flag.
- R8: cfg_ack is a one-cycle pulse. An access that is not forwarded is acknowledged on the first cycle after it is accepted. A forwarded access keeps bk_req high with a stable address until bk_ack, then raises cfg_ack on the following cycle. At most one backend request is outstanding.
- R9: Cursors do not change after a data-port access, so repeated accesses reach the same location.
- R10: The error flag stays set through later successful accesses until reset.
- R11: Reads of any other offset return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Host access request, held until cfg_ack |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Host write data |
| cfg_ack | output | 1 | One-cycle completion pulse |
| cfg_rdata | output | 32 | Read data, valid with cfg_ack |
| bk_req | output | 1 | Backend request, held until bk_ack |
| bk_we | output | 1 | Backend write flag |
| bk_space | output | 1 | 0 = register block, 1 = local memory |
| bk_addr | output | MEM_AW | Backend dword-aligned byte address |
| bk_wdata | output | 32 | Backend write data |
| bk_ack | input | 1 | Backend completion |
| bk_rdata | input | 32 | Backend read data, valid with bk_ack |
| err_flag | output | 1 | Sticky refused-access flag |

## Verification
The hardest situations to reach are the window edges of the register cursor: the last dword below the gap, the first dword of the upper window, and the first dword past it. A separate case is an access refused after a successful one, where the sticky flag must survive. The stimulus writes the cursor to each edge address in turn and issues both reads and writes there. Backend latency is varied from zero to several cycles, so the acknowledge timing and the hold of the request are seen under each delay.

// File: rtl/iwin_pkg.sv
// Shared constants and types for the indirect access window.
// Assumes byte offsets on an 8-bit configuration address.
package iwin_pkg;
    localparam int CFG_DW = 32;
    localparam int CFG_AW = 8;
    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h68;
    localparam logic [CFG_AW-1:0] OFS_RCUR = 8'h78;
    localparam logic [CFG_AW-1:0] OFS_MCUR = 8'h7C;
    localparam logic [CFG_AW-1:0] OFS_RDAT = 8'h80;
    localparam logic [CFG_AW-1:0] OFS_MDAT = 8'h84;
    localparam int EN_BIT = 7;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} seq_state_t;
endpackage

// File: rtl/iwin_cursor.sv
// Cursor register: keeps AW address bits with the two low bits forced to zero.
// Assumes AW >= 3 and a write strobe lasting one cycle per host write.
module iwin_cursor
    import iwin_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_DW-1:0] wdata,
    output logic [AW-1:0]     cur
);
    // Load the aligned position on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur <= '0;
        else if (wr_en) cur <= {wdata[AW-1:2], 2'b00};
    end
endmodule

// File: rtl/iwin_range_chk.sv
// Window check: flags an address lying in either of two half-open ranges.
// Assumes AW < 32 and LO <= HI for both windows.
module iwin_range_chk #(
    parameter int          AW     = 18,
    parameter logic [31:0] W0_LO  = 32'h0,
    parameter logic [31:0] W0_HI  = 32'h8000,
    parameter logic [31:0] W1_LO  = 32'h30000,
    parameter logic [31:0] W1_HI  = 32'h38800
) (
    input  logic [AW-1:0] addr,
    output logic          in_win
);
    logic [31:0] a32;
    // Widen and compare against both windows.
    always_comb begin
        a32    = {{(32-AW){1'b0}}, addr};
        in_win = ((a32 >= W0_LO) && (a32 < W0_HI)) ||
                 ((a32 >= W1_LO) && (a32 < W1_HI));
    end
endmodule

// File: rtl/iwin_seq.sv
// Access sequencer: decodes host requests, launches one backend transfer per
// allowed data-port access, refuses the rest and keeps the sticky error.
// Assumes the host holds its request stable until cfg_ack.
module iwin_seq
    import iwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [CFG_DW-1:0] local_rdata,
    input  logic              en,
    input  logic              rcur_ok,
    input  logic              bk_ack,
    input  logic [CFG_DW-1:0] bk_rdata,
    output logic              cfg_ack,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              bk_req,
    output logic              bk_we,
    output logic              bk_space,
    output logic [CFG_DW-1:0] bk_wdata,
    output logic              err_flag,
    output logic              ctrl_wr,
    output logic              rcur_wr,
    output logic              mcur_wr
);
    seq_state_t state;
    logic is_rdat, is_mdat, is_data, launch_ok, take;

    // Decode the pending request and whether it may reach the backend.
    always_comb begin
        take      = (state == ST_IDLE) && cfg_req;
        is_rdat   = (cfg_addr == OFS_RDAT);
        is_mdat   = (cfg_addr == OFS_MDAT);
        is_data   = is_rdat || is_mdat;
        launch_ok = en && (is_mdat || (is_rdat && rcur_ok));
        ctrl_wr   = take && cfg_we && (cfg_addr == OFS_CTRL);
        rcur_wr   = take && cfg_we && (cfg_addr == OFS_RCUR);
        mcur_wr   = take && cfg_we && (cfg_addr == OFS_MCUR);
        cfg_ack   = (state == ST_DONE);
    end

    // Step the request through idle, backend wait and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bk_req    <= 1'b0;
            bk_we     <= 1'b0;
            bk_space  <= 1'b0;
            bk_wdata  <= '0;
            cfg_rdata <= '0;
            err_flag  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cfg_req) begin
                    if (is_data && launch_ok) begin
                        state    <= ST_BUSY;
                        bk_req   <= 1'b1;
                        bk_we    <= cfg_we;
                        bk_space <= is_mdat;
                        bk_wdata <= cfg_wdata;
                    end else begin
                        state     <= ST_DONE;
                        cfg_rdata <= (is_data || cfg_we) ? '0 : local_rdata;
                        if (is_data) err_flag <= 1'b1;
                    end
                end
                ST_BUSY: if (bk_ack) begin
                    state     <= ST_DONE;
                    bk_req    <= 1'b0;
                    cfg_rdata <= bk_we ? '0 : bk_rdata;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_indirect_window.sv
// Indirect window top: control register, two cursors, window check and the
// sequencer, joined to the configuration port and the backend bus.
// Assumes MEM_AW >= REG_AW and both below 32.
module cfg_indirect_window
    import iwin_pkg::*;
#(
    parameter int          REG_AW  = 18,
    parameter int          MEM_AW  = 24,
    parameter logic [31:0] RWIN0_LO = 32'h0,
    parameter logic [31:0] RWIN0_HI = 32'h8000,
    parameter logic [31:0] RWIN1_LO = 32'h30000,
    parameter logic [31:0] RWIN1_HI = 32'h38800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              bk_req,
    output logic              bk_we,
    output logic              bk_space,
    output logic [MEM_AW-1:0] bk_addr,
    output logic [CFG_DW-1:0] bk_wdata,
    input  logic              bk_ack,
    input  logic [CFG_DW-1:0] bk_rdata,
    output logic              err_flag
);
    localparam int PAD_R = CFG_DW - REG_AW;
    localparam int PAD_M = CFG_DW - MEM_AW;

    logic              ctrl_en, ctrl_wr, rcur_wr, mcur_wr, rcur_ok;
    logic [REG_AW-1:0] rcur;
    logic [MEM_AW-1:0] mcur;
    logic [CFG_DW-1:0] local_rdata;

    // Hold the enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_en <= 1'b0;
        else if (ctrl_wr) ctrl_en <= cfg_wdata[EN_BIT];
    end

    iwin_cursor #(.AW(REG_AW)) u_rcur (
        .clk(clk), .rst_n(rst_n), .wr_en(rcur_wr), .wdata(cfg_wdata), .cur(rcur));

    iwin_cursor #(.AW(MEM_AW)) u_mcur (
        .clk(clk), .rst_n(rst_n), .wr_en(mcur_wr), .wdata(cfg_wdata), .cur(mcur));

    iwin_range_chk #(.AW(REG_AW), .W0_LO(RWIN0_LO), .W0_HI(RWIN0_HI),
                     .W1_LO(RWIN1_LO), .W1_HI(RWIN1_HI)) u_rchk (
        .addr(rcur), .in_win(rcur_ok));

    // Select readback for the non-data offsets.
    always_comb begin
        case (cfg_addr)
            OFS_CTRL: begin
                local_rdata         = '0;
                local_rdata[EN_BIT] = ctrl_en;
            end
            OFS_RCUR: local_rdata = {{PAD_R{1'b0}}, rcur};
            OFS_MCUR: local_rdata = {{PAD_M{1'b0}}, mcur};
            default:  local_rdata = '0;
        endcase
    end

    // Route the cursor of the active space to the backend.
    always_comb begin
        bk_addr = bk_space ? mcur : {{(MEM_AW-REG_AW){1'b0}}, rcur};
    end

    iwin_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .local_rdata(local_rdata),
        .en(ctrl_en), .rcur_ok(rcur_ok), .bk_ack(bk_ack), .bk_rdata(bk_rdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .bk_req(bk_req), .bk_we(bk_we),
        .bk_space(bk_space), .bk_wdata(bk_wdata), .err_flag(err_flag),
        .ctrl_wr(ctrl_wr), .rcur_wr(rcur_wr), .mcur_wr(mcur_wr));
endmodule

// File: rtl/iwin_chk.sv
// Property checker for the indirect window, bound into the top module.
// Assumes the default register-block windows.
module iwin_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_ack,
    input logic          bk_req,
    input logic          bk_ack,
    input logic          bk_space,
    input logic [AW-1:0] bk_addr,
    input logic          en,
    input logic          err_flag
);
    logic [31:0] a32;
    // Widen the backend address for the window test.
    always_comb a32 = {{(32-AW){1'b0}}, bk_addr};

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req && !bk_ack |=> bk_req && $stable(bk_addr) && $stable(bk_space));
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);
    p_busy_noack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req |-> !cfg_ack);
    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req && !bk_space |-> (a32 < 32'h8000) || (a32 >= 32'h30000 && a32 < 32'h38800));
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bk_req) |-> en);
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req |-> bk_addr[1:0] == 2'b00);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind cfg_indirect_window iwin_chk #(.AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_ack(cfg_ack), .bk_req(bk_req),
    .bk_ack(bk_ack), .bk_space(bk_space), .bk_addr(bk_addr),
    .en(ctrl_en), .err_flag(err_flag));

// File: tb/sim_cfg_indirect_window.sv
// Bench: behavioural model of the window plus a backend responder with
// variable latency; compares every transaction and the flags on every clock.
module sim_cfg_indirect_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;
    logic        bk_req, bk_we, bk_space;
    logic [23:0] bk_addr;
    logic [31:0] bk_wdata;
    logic        bk_ack = 1'b0;
    logic [31:0] bk_rdata = '0;
    logic        err_flag;

    int total = 0, bad = 0;
    int lat = 0, lcnt = 0, req_cnt = 0;
    bit exp_err = 0, exp_fwd = 0, done = 0;
    bit m_en = 0;
    logic [31:0] m_rcur = '0, m_mcur = '0;
    logic        last_we, last_space;
    logic [23:0] last_addr;
    logic [31:0] last_wdata;

    always #10 clk = ~clk;

    cfg_indirect_window u0 (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata), .bk_req(bk_req), .bk_we(bk_we),
        .bk_space(bk_space), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
        .bk_ack(bk_ack), .bk_rdata(bk_rdata), .err_flag(err_flag));

    function automatic logic [31:0] pat(input logic sp, input logic [23:0] a);
        return {(sp ? 8'hC3 : 8'h3C), a};
    endfunction

    function automatic bit in_win(input logic [31:0] a);
        return (a < 32'h8000) || (a >= 32'h30000 && a < 32'h38800);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Backend responder: acknowledges after lat cycles, one transfer at a time.
    always @(negedge clk) begin
        if (!bk_req) begin
            bk_ack = 1'b0;
            lcnt = 0;
        end else if (!bk_ack) begin
            if (lcnt >= lat) begin
                bk_ack     = 1'b1;
                bk_rdata   = pat(bk_space, bk_addr);
                req_cnt++;
                last_we    = bk_we;
                last_space = bk_space;
                last_addr  = bk_addr;
                last_wdata = bk_wdata;
            end else lcnt++;
        end else bk_ack = 1'b0;
    end

    // Per-clock comparison of the error flag and unexpected backend requests.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check("R10 err flag", {31'b0, err_flag}, {31'b0, exp_err});
            if (bk_req && !exp_fwd) check("R7 unexpected bk_req", 32'd1, 32'd0);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_en = 0; m_rcur = '0; m_mcur = '0; exp_err = 0;
    endtask

    task automatic xfer(input string tag, input bit we, input logic [7:0] addr,
                        input logic [31:0] wd);
        bit is_data, fwd, sp;
        int cyc, start;
        logic [31:0] exp_rd, tgt;
        is_data = (addr == 8'h80) || (addr == 8'h84);
        sp      = (addr == 8'h84);
        tgt     = sp ? m_mcur : m_rcur;
        fwd     = m_en && (sp || (addr == 8'h80 && in_win(m_rcur)));
        if (we || (is_data && !fwd)) exp_rd = '0;
        else if (is_data)            exp_rd = pat(sp, tgt[23:0]);
        else if (addr == 8'h68)      exp_rd = {24'b0, m_en, 7'b0};
        else if (addr == 8'h78)      exp_rd = m_rcur;
        else if (addr == 8'h7C)      exp_rd = m_mcur;
        else                         exp_rd = '0;
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
        exp_fwd = fwd;
        if (is_data && !fwd) exp_err = 1;
        start = req_cnt;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cfg_ack && cyc < 200);
        cfg_req = 1'b0;
        check({tag, " rdata"}, cfg_rdata, exp_rd);
        check({tag, " ack latency (R8)"}, cyc, fwd ? lat + 2 : 1);
        check({tag, " backend count"}, req_cnt - start, fwd ? 1 : 0);
        if (fwd) begin
            check({tag, " bk_addr"}, {8'b0, last_addr}, tgt);
            check({tag, " bk_space"}, {31'b0, last_space}, {31'b0, sp});
            check({tag, " bk_we"}, {31'b0, last_we}, {31'b0, we});
            if (we) check({tag, " bk_wdata"}, last_wdata, wd);
        end
        @(negedge clk);
        check({tag, " ack pulse (R8)"}, {31'b0, cfg_ack}, 32'd0);
        exp_fwd = 0;
        if (we && addr == 8'h68) m_en = wd[7];
        if (we && addr == 8'h78) m_rcur = wd & 32'h0003_FFFC;
        if (we && addr == 8'h7C) m_mcur = wd & 32'h00FF_FFFC;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 bk_req at reset", {31'b0, bk_req}, 32'd0);
        check("R1 err at reset", {31'b0, err_flag}, 32'd0);
        xfer("R1 ctrl", 0, 8'h68, 0);
        xfer("R1 rcur", 0, 8'h78, 0);
        xfer("R1 mcur", 0, 8'h7C, 0);
        // R11: unmapped offsets
        xfer("R11 wr 0x70", 1, 8'h70, 32'hFFFF_FFFF);
        xfer("R11 rd 0x70", 0, 8'h70, 0);
        xfer("R11 ctrl kept", 0, 8'h68, 0);
        // R3: cursor widths and alignment
        xfer("R3 wr rcur", 1, 8'h78, 32'hFFFF_FFFF);
        xfer("R3 rd rcur", 0, 8'h78, 0);
        xfer("R3 wr mcur", 1, 8'h7C, 32'hFFFF_FFFF);
        xfer("R3 rd mcur", 0, 8'h7C, 0);
        // R2: only bit 7 stored
        xfer("R2 wr ctrl", 1, 8'h68, 32'hFFFF_FF7F);
        xfer("R2 rd ctrl", 0, 8'h68, 0);
        xfer("R2 wr ctrl en", 1, 8'h68, 32'h0000_0080);
        xfer("R2 rd ctrl en", 0, 8'h68, 0);
        // R4: register window edges, varied latency
        for (int i = 0; i < 4; i++) begin
            logic [31:0] edges [4];
            edges = '{32'h0, 32'h7FFC, 32'h30000, 32'h387FC};
            lat = i;
            xfer("R4 set rcur", 1, 8'h78, edges[i] | 32'h3);
            xfer("R4 rd reg", 0, 8'h80, 0);
            xfer("R4 wr reg", 1, 8'h80, 32'hA000_0000 + i);
        end
        // R9: no auto-increment
        lat = 1;
        xfer("R9 rd again", 0, 8'h80, 0);
        xfer("R9 rcur kept", 0, 8'h78, 0);
        // R5: memory window
        xfer("R5 set mcur", 1, 8'h7C, 32'h00AB_CDE4);
        xfer("R5 rd mem", 0, 8'h84, 0);
        lat = 3;
        xfer("R5 wr mem", 1, 8'h84, 32'h1234_5678);
        xfer("R9 mcur kept", 0, 8'h7C, 0);
        check("R6 no err yet", {31'b0, err_flag}, 32'd0);
        // R6: gap and upper edge
        lat = 0;
        xfer("R6 set gap lo", 1, 8'h78, 32'h8000);
        xfer("R6 rd gap lo", 0, 8'h80, 0);
        xfer("R6 wr gap lo", 1, 8'h80, 32'hDEAD_BEEF);
        xfer("R6 set gap hi", 1, 8'h78, 32'h2FFFC);
        xfer("R6 rd gap hi", 0, 8'h80, 0);
        xfer("R6 set past top", 1, 8'h78, 32'h38800);
        xfer("R6 rd past top", 0, 8'h80, 0);
        // R10: sticky through a good access
        xfer("R10 mem ok", 0, 8'h84, 0);
        check("R10 still set", {31'b0, err_flag}, 32'd1);
        do_reset();
        check("R1 err cleared", {31'b0, err_flag}, 32'd0);
        // R7: enable clear
        xfer("R7 set rcur", 1, 8'h78, 32'h100);
        xfer("R7 rd reg off", 0, 8'h80, 0);
        xfer("R7 wr mem off", 1, 8'h84, 32'h5555_AAAA);
        xfer("R7 en on", 1, 8'h68, 32'h80);
        xfer("R7 rd reg on", 0, 8'h80, 0);
        xfer("R7 en off", 1, 8'h68, 32'h0);
        xfer("R7 rd mem off", 0, 8'h84, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule